// File: doc/BRIEF.md
# Host Register and Switch-Memory Access Port

This block is the parallel host-side access port of a time-slot switch. A host drives a six-bit address, an eight-bit data word, a select, a strobe and a read/write level. The port uses them to reach a single control register, or one location of the switch memories. Those memories are the low connection memory, the high connection memory and the read-only data memory, each holding 256 bytes arranged as 8 streams of 32 channels.

The control register chooses the memory and the stream. The low five address bits choose the channel. A split bit in the register sends every host read to the data memory and every host write to the low connection memory, whatever memory the register otherwise selects.

The memories are shared with the TDM engine. A memory access therefore waits for a cycle in which the slot sequencer grants the host a slot. The acknowledge rises only once the access has been served. It stays high until the host releases the select or the strobe.

Top module: `hap_host_port`

## Requirements
- R1: After synchronous reset the control register is 0, `proc_en` is 0, `host_ack` is 0 and `mem_req` is 0.
- R2: An access with address bit 5 low and address bits 1:0 both low reaches the control register. Address bits 4:2 are don't-care. A read returns the register value and a write replaces it.
- R3: An access with address bit 5 low and address bits 1:0 not both low is unmapped. A read returns 0, a write changes nothing, and the acknowledge still completes.
- R4: With address bit 5 high, the memory address is {control bits 2:0 (stream), address bits 4:0 (channel)}. The memory is chosen by control bits 4:3: 00 selects the low connection memory (`mem_tgt`=00), 01 the high connection memory (`mem_tgt`=01), and 10 or 11 the data memory (`mem_tgt`=10).
- R5: While control bit 7 (split) is 1, memory reads go to the data memory and memory writes go to the low connection memory, whatever bits 4:3 hold.
- R6: Control bit 6 is the processor enable and is presented on `proc_en`.
- R7: A write that targets the data memory issues no memory request and leaves the data memory unchanged, yet the acknowledge still completes.
- R8: `mem_req` is raised only in a cycle where `tdm_host_slot` is 1. A memory access without a granted slot leaves `host_ack` low.
- R9: `host_ack` rises after the access is served and stays high while select and strobe are both held. It falls on the cycle after either one is released.
- R10: Each served memory access raises `mem_req` for exactly one cycle. Read data is taken from `mem_rdata` one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host chip select, active high |
| host_stb | input | 1 | Host data strobe, active high |
| host_rd | input | 1 | 1 = read, 0 = write |
| host_addr | input | 6 | Host address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid while `host_ack` is high |
| host_ack | output | 1 | Access complete acknowledge |
| tdm_host_slot | input | 1 | Slot sequencer grants the host this memory cycle |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_tgt | output | 2 | Target memory: 00 low conn, 01 high conn, 10 data |
| mem_addr | output | 8 | Memory address {stream, channel} |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after request |
| proc_en | output | 1 | Global processor enable from the control register |

## Verification
The hardest situation to reach from the ports is a memory access that is kept waiting. For it, the host strobe must be held for many cycles while the TDM engine grants no slot. The bench gates its slot pattern off for a stretch and confirms that neither an acknowledge nor a request appears. It then reopens the slot and checks that exactly one request and one acknowledge follow. The split routing is also hard to see, because the memory it picks differs for the read and the write. It is brought out by writing under split and reading back after split is cleared.

// File: rtl/hap_pkg.sv
package hap_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 6;
    localparam int CHAN_W   = 5;
    localparam int STREAM_W = 3;
    localparam int MEM_AW   = CHAN_W + STREAM_W;

    typedef struct packed {
        logic                split;
        logic                proc_en;
        logic                spare;
        logic [1:0]          msel;
        logic [STREAM_W-1:0] stream;
    } ctrl_t;

    typedef enum logic [1:0] {
        TGT_CML = 2'b00,
        TGT_CMH = 2'b01,
        TGT_DM  = 2'b10
    } mem_tgt_e;

    typedef enum logic [1:0] {
        K_REG  = 2'b00,
        K_NONE = 2'b01,
        K_MEM  = 2'b10,
        K_DROP = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'b00,
        S_WAIT  = 2'b01,
        S_FETCH = 2'b10,
        S_DONE  = 2'b11
    } fsm_e;

    function automatic mem_tgt_e msel_to_tgt(input logic [1:0] msel);
        case (msel)
            2'b00:   return TGT_CML;
            2'b01:   return TGT_CMH;
            default: return TGT_DM;
        endcase
    endfunction
endpackage

// File: rtl/hap_ctrl_reg.sv
module hap_ctrl_reg
    import hap_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output ctrl_t         ctrl
);
    always_ff @(posedge clk) begin
        if (rst)     ctrl <= '0;
        else if (we) ctrl <= ctrl_t'(wdata);
    end
endmodule

// File: rtl/hap_decode.sv
module hap_decode
    import hap_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int CW  = CHAN_W,
    parameter int MAW = MEM_AW
) (
    input  logic [AW-1:0]  addr,
    input  logic           is_rd,
    input  ctrl_t          ctrl,
    output acc_kind_e      kind,
    output mem_tgt_e       tgt,
    output logic [MAW-1:0] maddr
);
    always_comb begin
        maddr = {ctrl.stream, addr[CW-1:0]};
        if (ctrl.split) tgt = is_rd ? TGT_DM : TGT_CML;
        else            tgt = msel_to_tgt(ctrl.msel);
        if (!addr[AW-1]) begin
            kind = (addr[1:0] == 2'b00) ? K_REG : K_NONE;
        end else if (tgt == TGT_DM && !is_rd) begin
            kind = K_DROP;
        end else begin
            kind = K_MEM;
        end
    end
endmodule

// File: rtl/hap_arb_fsm.sv
module hap_arb_fsm
    import hap_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int MAW = MEM_AW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go,
    input  logic           is_rd,
    input  acc_kind_e      kind,
    input  mem_tgt_e       tgt_in,
    input  logic [MAW-1:0] maddr_in,
    input  logic [DW-1:0]  wdata_in,
    input  logic [DW-1:0]  ctrl_rdata,
    input  logic           slot,
    input  logic [DW-1:0]  mem_rdata,
    output logic           mem_req,
    output logic           mem_we,
    output mem_tgt_e       mem_tgt,
    output logic [MAW-1:0] mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic           reg_we,
    output logic [DW-1:0]  rdata,
    output logic           ack
);
    fsm_e state, state_nx;
    logic start;

    assign start   = (state == S_IDLE) && go;
    assign reg_we  = start && (kind == K_REG) && !is_rd;
    assign mem_req = (state == S_WAIT) && go && slot;
    assign ack     = (state == S_DONE);

    always_comb begin
        state_nx = state;
        case (state)
            S_IDLE:  if (go) state_nx = (kind == K_MEM) ? S_WAIT : S_DONE;
            S_WAIT:  if (!go)       state_nx = S_IDLE;
                     else if (slot) state_nx = mem_we ? S_DONE : S_FETCH;
            S_FETCH: state_nx = S_DONE;
            S_DONE:  if (!go) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            mem_we    <= 1'b0;
            mem_tgt   <= TGT_CML;
            mem_addr  <= '0;
            mem_wdata <= '0;
            rdata     <= '0;
        end else begin
            state <= state_nx;
            if (start) begin
                mem_we    <= !is_rd;
                mem_tgt   <= tgt_in;
                mem_addr  <= maddr_in;
                mem_wdata <= wdata_in;
                rdata     <= (kind == K_REG && is_rd) ? ctrl_rdata : '0;
            end
            if (state == S_FETCH) rdata <= mem_rdata;
        end
    end

    // R8: a memory cycle is used only when the sequencer grants it
    a_r8_req_in_slot: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> slot);
    // R10: one request per access
    a_r10_single_req: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);
    // R9: acknowledge held while the host holds the access
    a_r9_ack_hold: assert property (@(posedge clk) disable iff (rst)
        (ack && go) |=> ack);
    // R9: acknowledge released one cycle after the host lets go
    a_r9_ack_drop: assert property (@(posedge clk) disable iff (rst)
        (ack && !go) |=> !ack);
    // R7: no write ever reaches the data memory
    a_r7_no_dm_write: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_tgt != TGT_DM));
endmodule

// File: rtl/hap_host_port.sv
module hap_host_port
    import hap_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W,
    parameter int MAW = MEM_AW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           host_sel,
    input  logic           host_stb,
    input  logic           host_rd,
    input  logic [AW-1:0]  host_addr,
    input  logic [DW-1:0]  host_wdata,
    output logic [DW-1:0]  host_rdata,
    output logic           host_ack,
    input  logic           tdm_host_slot,
    output logic           mem_req,
    output logic           mem_we,
    output logic [1:0]     mem_tgt,
    output logic [MAW-1:0] mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic           proc_en
);
    ctrl_t          ctrl;
    acc_kind_e      kind;
    mem_tgt_e       dec_tgt;
    mem_tgt_e       cur_tgt;
    logic [MAW-1:0] dec_addr;
    logic           reg_we;
    logic           go;

    assign go      = host_sel && host_stb;
    assign proc_en = ctrl.proc_en;
    assign mem_tgt = cur_tgt;

    hap_ctrl_reg #(.DW(DW)) u_ctrl (
        .clk(clk), .rst(rst), .we(reg_we), .wdata(host_wdata), .ctrl(ctrl)
    );

    hap_decode #(.AW(AW), .CW(CHAN_W), .MAW(MAW)) u_dec (
        .addr(host_addr), .is_rd(host_rd), .ctrl(ctrl),
        .kind(kind), .tgt(dec_tgt), .maddr(dec_addr)
    );

    hap_arb_fsm #(.DW(DW), .MAW(MAW)) u_fsm (
        .clk(clk), .rst(rst), .go(go), .is_rd(host_rd), .kind(kind),
        .tgt_in(dec_tgt), .maddr_in(dec_addr), .wdata_in(host_wdata),
        .ctrl_rdata(DW'(ctrl)), .slot(tdm_host_slot), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_tgt(cur_tgt),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .reg_we(reg_we),
        .rdata(host_rdata), .ack(host_ack)
    );

    // R5: under split, writes land in low connection memory, reads in data memory
    a_r5_split_route: assert property (@(posedge clk) disable iff (rst)
        (mem_req && ctrl.split) |-> (mem_we ? (cur_tgt == TGT_CML) : (cur_tgt == TGT_DM)));
    // R6: processor enable follows control bit 6
    a_r6_proc_en: assert property (@(posedge clk) disable iff (rst)
        $past(reg_we) |-> (proc_en == $past(host_wdata[6])));
endmodule

// File: tb/hap_host_port_bench.sv
`timescale 1ns/1ps
module hap_host_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_sel = 1'b0, host_stb = 1'b0, host_rd = 1'b0;
    logic [5:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_ack;
    logic       tdm_host_slot = 1'b0;
    logic       mem_req, mem_we;
    logic [1:0] mem_tgt;
    logic [7:0] mem_addr, mem_wdata;
    logic [7:0] mem_rdata = '0;
    logic       proc_en;

    int checks = 0, fails = 0, req_cnt = 0, slot_ph = 0;
    logic slot_en = 1'b1;
    logic [7:0] cml [256];
    logic [7:0] cmh [256];
    logic [7:0] dm  [256];

    always #4 clk = ~clk;

    hap_host_port u_hap_host_port (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_stb(host_stb),
        .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_ack(host_ack), .tdm_host_slot(tdm_host_slot),
        .mem_req(mem_req), .mem_we(mem_we), .mem_tgt(mem_tgt), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .proc_en(proc_en)
    );

    initial begin
        for (int i = 0; i < 256; i++) begin
            cml[i] = '0; cmh[i] = '0; dm[i] = 8'(i) ^ 8'h5A;
        end
    end

    // memory model with one-cycle read latency; writes go wherever mem_tgt says
    always @(posedge clk) begin
        if (mem_req) begin
            req_cnt <= req_cnt + 1;
            if (mem_we) begin
                case (mem_tgt)
                    2'b00:   cml[mem_addr] <= mem_wdata;
                    2'b01:   cmh[mem_addr] <= mem_wdata;
                    default: dm[mem_addr]  <= mem_wdata;
                endcase
            end else begin
                case (mem_tgt)
                    2'b00:   mem_rdata <= cml[mem_addr];
                    2'b01:   mem_rdata <= cmh[mem_addr];
                    default: mem_rdata <= dm[mem_addr];
                endcase
            end
        end
    end

    // slot sequencer: one host slot in three cycles
    always @(negedge clk) begin
        slot_ph       <= (slot_ph == 2) ? 0 : slot_ph + 1;
        tdm_host_slot <= slot_en && (slot_ph == 0);
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic access(input logic rd, input logic [5:0] a, input logic [7:0] wd,
                          output logic [7:0] rdv, output int nreq);
        int n = 0;
        int r0;
        @(negedge clk);
        r0 = req_cnt;
        host_rd = rd; host_addr = a; host_wdata = wd; host_sel = 1'b1; host_stb = 1'b1;
        do begin
            @(negedge clk); n++;
        end while (!host_ack && n < 500);
        rdv = host_rdata;
        check("R9 ack rises", 8'(host_ack), 8'h01);
        host_sel = 1'b0; host_stb = 1'b0;
        @(negedge clk);
        check("R9 ack falls", 8'(host_ack), 8'h00);
        nreq = req_cnt - r0;
    endtask

    // {rd, addr, wdata, expected read, expected request count}
    localparam int NV = 20;
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 6'h00, 8'h08, 8'h00, 2'd0},  // R2 ctrl: CMH, stream 0
        {1'b1, 6'h1C, 8'h00, 8'h08, 2'd0},  // R2 ctrl read, A4..A2 don't care
        {1'b0, 6'h25, 8'hA1, 8'h00, 2'd1},  // R4 CMH[0][5]
        {1'b0, 6'h00, 8'h03, 8'h00, 2'd0},  // R4 ctrl: CML, stream 3
        {1'b0, 6'h25, 8'h3C, 8'h00, 2'd1},  // R4 CML[3][5]
        {1'b1, 6'h25, 8'h00, 8'h3C, 2'd1},  // R4 read CML
        {1'b0, 6'h00, 8'h08, 8'h00, 2'd0},  // R4 ctrl: CMH stream 0
        {1'b1, 6'h25, 8'h00, 8'hA1, 2'd1},  // R4 read CMH
        {1'b0, 6'h00, 8'h12, 8'h00, 2'd0},  // R4 ctrl: DM stream 2
        {1'b1, 6'h27, 8'h00, 8'h1D, 2'd1},  // R4 DM[0x47]
        {1'b0, 6'h27, 8'hFF, 8'h00, 2'd0},  // R7 DM write dropped
        {1'b1, 6'h27, 8'h00, 8'h1D, 2'd1},  // R7 DM unchanged
        {1'b0, 6'h02, 8'h77, 8'h00, 2'd0},  // R3 unmapped write
        {1'b1, 6'h02, 8'h00, 8'h00, 2'd0},  // R3 unmapped read is 0
        {1'b1, 6'h00, 8'h00, 8'h12, 2'd0},  // R3 ctrl untouched
        {1'b0, 6'h00, 8'h8B, 8'h00, 2'd0},  // R5 split on, msel CMH, stream 3
        {1'b0, 6'h29, 8'h5E, 8'h00, 2'd1},  // R5 write -> CML[3][9]
        {1'b1, 6'h29, 8'h00, 8'h33, 2'd1},  // R5 read -> DM[0x69]
        {1'b0, 6'h00, 8'h03, 8'h00, 2'd0},  // R5 split off, CML stream 3
        {1'b1, 6'h29, 8'h00, 8'h5E, 2'd1}   // R5 write landed in CML
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] rv;
        int nr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 ack", 8'(host_ack), 8'h00);
        check("R1 proc_en", 8'(proc_en), 8'h00);
        check("R1 mem_req", 8'(mem_req), 8'h00);
        access(1'b1, 6'h00, 8'h00, rv, nr);
        check("R1 ctrl zero", rv, 8'h00);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][24], VEC[i][23:18], VEC[i][17:10], rv, nr);
            if (VEC[i][24]) check($sformatf("R2-table vec %0d read", i), rv, VEC[i][9:2]);
            check($sformatf("R10 vec %0d req count", i), 8'(nr), 8'(VEC[i][1:0]));
        end

        // R6 processor enable
        access(1'b0, 6'h00, 8'h43, rv, nr);
        check("R6 proc_en set", 8'(proc_en), 8'h01);
        access(1'b0, 6'h00, 8'h03, rv, nr);
        check("R6 proc_en clear", 8'(proc_en), 8'h00);

        // R8 no slot: access must stall without request or ack
        begin
            int r0;
            @(negedge clk);
            slot_en = 1'b0;
            repeat (2) @(negedge clk);
            r0 = req_cnt;
            host_rd = 1'b1; host_addr = 6'h25; host_sel = 1'b1; host_stb = 1'b1;
            repeat (20) @(negedge clk);
            check("R8 no ack without slot", 8'(host_ack), 8'h00);
            check("R8 no req without slot", 8'(req_cnt - r0), 8'h00);
            slot_en = 1'b1;
            repeat (8) @(negedge clk);
            check("R8 ack after slot", 8'(host_ack), 8'h01);
            check("R10 single req", 8'(req_cnt - r0), 8'h01);
            check("R4 stalled read data", host_rdata, 8'h3C);
            // R9 hold while strobe held
            repeat (4) @(negedge clk);
            check("R9 ack held", 8'(host_ack), 8'h01);
            host_stb = 1'b0;
            @(negedge clk);
            check("R9 ack drops on strobe release", 8'(host_ack), 8'h00);
            host_sel = 1'b0;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule